// File: doc/BRIEF.md
# Dual-Byte Packet Receive Deformatter

This block sits on the link side of a PHY-to-link parallel interface. It samples a 2-bit control code, a low data lane, a high data lane and a high-lane valid flag on every interface clock. From this stream it recognises the start-of-packet announcement, captures any status byte the PHY sends while announcing, decodes the speed byte and then collects packet bytes. The bytes leave as a stream of up to two bytes per clock, with a last-byte marker.

At the fastest speed the interface carries two bytes per clock. The low lane holds the earlier byte and the high lane the later one. On the closing cycle of a packet with an odd byte count, the valid flag is low and the high lane must be discarded. At the second-fastest speed only the low lane carries data, one byte per clock. At the four slower speeds each byte is held on the low lane for several clocks and is taken only on the first clock of each hold. When the high lane floats (high impedance), the board's pull-down makes it read as not valid. A speed byte with an undefined code raises a one-cycle error pulse, and the packet that follows is thrown away.

Top module: `dual_rx_deformatter`

## Requirements
- R1: After reset, out_valid_o, out_last_o, out_two_o, spd_err_o and stat_valid_o are 0, and spd_o reads 0.
- R2: A packet is only accepted after an announcement: control 2'b10 with low byte 8'hFF seen from idle. Data-phase cycles with no prior announcement produce no output bytes.
- R3: Control 2'b01 during idle or announcement copies the low byte to stat_o and pulses stat_valid_o for exactly one clock, one cycle after it is sampled.
- R4: The first control-2'b10 cycle after the announcement whose low byte is not 8'hFF is the speed byte. The decoding is: 00 and 01 give spd_o=0; 04 and 05 give 1; 08 and 09 give 2; 0D gives 3; 0F gives 4; 0B gives 5. legacy_o is 1 for 00, 04 and 08 and 0 for the other defined codes.
- R5: Any other speed byte pulses spd_err_o for one clock, and the following packet produces no output bytes.
- R6: At spd_o=5, each data cycle delivers the low lane as out_data_o[7:0] and the high lane as out_data_o[15:8], with out_two_o=1. Byte order in the stream equals arrival order.
- R7: At spd_o=5, a data cycle with the valid flag 0 contributes only its low-lane byte (out_two_o=0), whatever the high lane holds.
- R8: At spd_o=4 and below, one byte per accepted cycle comes from the low lane only. The high lane and the valid flag have no effect.
- R9: At spd_o 3, 2, 1 and 0, each byte occupies 2, 4, 8 and 16 clocks respectively, and exactly one copy, the first, is delivered.
- R10: Exactly one output word per packet carries out_last_o=1, and it holds the final byte. out_two_o=1 only occurs when spd_o=5.
- R11: A packet ends on the first cycle whose control is not 2'b10. The last word is delivered one clock after that cycle is sampled, and every other word one clock after a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_i | input | 2 | Control code from the PHY |
| dlo_i | input | 8 | Low data lane |
| dhi_i | input | 8 | High data lane |
| hv_i | input | 1 | High-lane valid flag (pulled low when floating) |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 16 | Output bytes, earlier byte in bits 7:0 |
| out_two_o | output | 1 | Bits 15:8 also carry a byte |
| out_last_o | output | 1 | Word holds the final packet byte |
| spd_o | output | 3 | Decoded speed of the current packet |
| legacy_o | output | 1 | Speed byte used the legacy format |
| spd_err_o | output | 1 | Undefined speed byte seen |
| stat_valid_o | output | 1 | Status byte captured |
| stat_o | output | 8 | Captured status byte |

## Verification
Randomly sized packets with random contents are sent at every speed. The comparison of byte order and count tells a correct lane order and repeat sampling apart from swapped lanes, duplicated copies or skipped copies. Odd and even lengths at the top speed separate the handling of the valid flag from a design that always uses the high lane. Garbage on the high lane at slower speeds exposes any leak from that lane. Directed packets cover all nine defined speed codes, an undefined code, a status byte, and data that arrives with no announcement.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [2:0] {
      SPD_S100  = 3'd0,
      SPD_S200  = 3'd1,
      SPD_S400  = 3'd2,
      SPD_S800  = 3'd3,
      SPD_S1600 = 3'd4,
      SPD_S3200 = 3'd5
   } rxd_speed_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DON  = 2'd1,
      ST_DATA = 2'd2,
      ST_DROP = 2'd3
   } rxd_state_e;

   localparam logic [1:0] CTL_STAT = 2'b01;
   localparam logic [1:0] CTL_DATA = 2'b10;
   localparam logic [7:0] DATA_ON_CODE = 8'hFF;
endpackage

// File: rtl/rxd_spd_decode.sv
module rxd_spd_decode
   import rxd_pkg::*;
#(
   parameter bit HAS_HIGH_LANE = 1'b1
) (
   input  logic [7:0] code_i,
   output rxd_speed_e spd_o,
   output logic       legacy_o,
   output logic       reserved_o
);
   always_comb begin
      spd_o      = SPD_S100;
      legacy_o   = 1'b0;
      reserved_o = 1'b0;
      unique case (code_i)
         8'h00: begin spd_o = SPD_S100; legacy_o = 1'b1; end
         8'h01: spd_o = SPD_S100;
         8'h04: begin spd_o = SPD_S200; legacy_o = 1'b1; end
         8'h05: spd_o = SPD_S200;
         8'h08: begin spd_o = SPD_S400; legacy_o = 1'b1; end
         8'h09: spd_o = SPD_S400;
         8'h0D: spd_o = SPD_S800;
         8'h0F: spd_o = SPD_S1600;
         8'h0B: begin
            if (HAS_HIGH_LANE) spd_o = SPD_S3200;
            else               reserved_o = 1'b1;
         end
         default: reserved_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/rxd_pacer.sv
module rxd_pacer #(
   parameter int CW   = 4,
   parameter int LOGW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            run_i,
   input  logic [LOGW-1:0] log_rep_i,
   output logic            take_o
);
   localparam int MW = CW + 1;

   logic [CW-1:0] cnt_q;
   logic [MW-1:0] mask_w;

   assign mask_w = (MW'(1) << log_rep_i) - MW'(1);
   assign take_o = ((cnt_q & mask_w[CW-1:0]) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) cnt_q <= '0;
      else if (run_i)        cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/rxd_hold.sv
module rxd_hold #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              close_i,
   input  logic [2*LANE_W-1:0] word_i,
   input  logic              two_i,
   output logic              out_valid_o,
   output logic [2*LANE_W-1:0] out_data_o,
   output logic              out_two_o,
   output logic              out_last_o
);
   localparam int W = 2 * LANE_W;

   logic         pend_v_q;
   logic [W-1:0] pend_d_q;
   logic         pend_two_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v_q    <= 1'b0;
         pend_d_q    <= '0;
         pend_two_q  <= 1'b0;
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         out_two_o   <= 1'b0;
         out_last_o  <= 1'b0;
      end else begin
         out_valid_o <= 1'b0;
         out_last_o  <= 1'b0;
         out_two_o   <= 1'b0;
         if (take_i) begin
            if (pend_v_q) begin
               out_valid_o <= 1'b1;
               out_data_o  <= pend_d_q;
               out_two_o   <= pend_two_q;
            end
            pend_v_q   <= 1'b1;
            pend_d_q   <= word_i;
            pend_two_q <= two_i;
         end else if (close_i) begin
            if (pend_v_q) begin
               out_valid_o <= 1'b1;
               out_last_o  <= 1'b1;
               out_data_o  <= pend_d_q;
               out_two_o   <= pend_two_q;
            end
            pend_v_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dual_rx_deformatter.sv
module dual_rx_deformatter
   import rxd_pkg::*;
#(
   parameter bit HAS_HIGH_LANE = 1'b1,
   parameter int REP_S100      = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  ctl_i,
   input  logic [7:0]  dlo_i,
   input  logic [7:0]  dhi_i,
   input  logic        hv_i,
   output logic        out_valid_o,
   output logic [15:0] out_data_o,
   output logic        out_two_o,
   output logic        out_last_o,
   output logic [2:0]  spd_o,
   output logic        legacy_o,
   output logic        spd_err_o,
   output logic        stat_valid_o,
   output logic [7:0]  stat_o
);
   localparam int LOG_MAX = $clog2(REP_S100);
   localparam int CW      = LOG_MAX;
   localparam int LOGW    = $clog2(LOG_MAX + 1);

   if ((REP_S100 & (REP_S100 - 1)) != 0 || REP_S100 < 8) begin : g_bad_rep
      $error("REP_S100 must be a power of two of at least 8");
   end

   rxd_state_e       state_q;
   rxd_speed_e       spd_q;
   logic             leg_q;
   rxd_speed_e       dec_spd;
   logic             dec_leg;
   logic             dec_res;
   logic             is_data;
   logic             spd_cycle;
   logic             take;
   logic             close;
   logic             pace_take;
   logic             pace_run;
   logic [LOGW-1:0]  log_rep;
   logic [7:0]       hi_lane;
   logic             two;

   assign is_data   = (ctl_i == CTL_DATA);
   assign spd_cycle = (state_q == ST_DON) && is_data && (dlo_i != DATA_ON_CODE);
   assign pace_run  = (state_q == ST_DATA) && is_data;
   assign take      = pace_run && pace_take;
   assign close     = (state_q == ST_DATA) && !is_data;

   always_comb begin
      unique case (spd_q)
         SPD_S100: log_rep = LOGW'(LOG_MAX);
         SPD_S200: log_rep = LOGW'(LOG_MAX - 1);
         SPD_S400: log_rep = LOGW'(LOG_MAX - 2);
         SPD_S800: log_rep = LOGW'(LOG_MAX - 3);
         default:  log_rep = '0;
      endcase
   end

   if (HAS_HIGH_LANE) begin : g_high
      assign hi_lane = dhi_i;
      assign two     = (spd_q == SPD_S3200) && (hv_i == 1'b1);
   end else begin : g_low_only
      assign hi_lane = '0;
      assign two     = 1'b0;
   end

   rxd_spd_decode #(.HAS_HIGH_LANE(HAS_HIGH_LANE)) u_dec (
      .code_i    (dlo_i),
      .spd_o     (dec_spd),
      .legacy_o  (dec_leg),
      .reserved_o(dec_res)
   );

   rxd_pacer #(.CW(CW), .LOGW(LOGW)) u_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (spd_cycle),
      .run_i    (pace_run),
      .log_rep_i(log_rep),
      .take_o   (pace_take)
   );

   rxd_hold #(.LANE_W(8)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .close_i    (close),
      .word_i     ({hi_lane, dlo_i}),
      .two_i      (two),
      .out_valid_o(out_valid_o),
      .out_data_o (out_data_o),
      .out_two_o  (out_two_o),
      .out_last_o (out_last_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         spd_q        <= SPD_S100;
         leg_q        <= 1'b0;
         spd_err_o    <= 1'b0;
         stat_valid_o <= 1'b0;
         stat_o       <= '0;
      end else begin
         spd_err_o    <= 1'b0;
         stat_valid_o <= 1'b0;
         if ((state_q == ST_IDLE || state_q == ST_DON) && ctl_i == CTL_STAT) begin
            stat_o       <= dlo_i;
            stat_valid_o <= 1'b1;
         end
         unique case (state_q)
            ST_IDLE: if (is_data && dlo_i == DATA_ON_CODE) state_q <= ST_DON;
            ST_DON: begin
               if (spd_cycle) begin
                  if (dec_res) begin
                     spd_err_o <= 1'b1;
                     state_q   <= ST_DROP;
                  end else begin
                     spd_q   <= dec_spd;
                     leg_q   <= dec_leg;
                     state_q <= ST_DATA;
                  end
               end else if (!is_data && ctl_i != CTL_STAT) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_DATA: if (!is_data) state_q <= ST_IDLE;
            ST_DROP: if (!is_data) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spd_o    = spd_q;
   assign legacy_o = leg_q;
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] ctl_i,
   input logic       out_valid_o,
   input logic       out_two_o,
   input logic       out_last_o,
   input logic [2:0] spd_o,
   input logic       spd_err_o,
   input logic       stat_valid_o
);
   assert_last_has_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> out_valid_o);

   assert_two_only_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_two_o |-> (out_valid_o && spd_o == 3'd5));

   assert_last_after_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> $past(ctl_i) != 2'b10);

   assert_mid_after_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_last_o) |-> $past(ctl_i) == 2'b10);

   assert_err_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      spd_err_o |=> (!spd_err_o && !out_valid_o));

   assert_stat_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid_o |-> $past(ctl_i) == 2'b01);
endmodule

bind dual_rx_deformatter rxd_checker u_rxd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_i       (ctl_i),
   .out_valid_o (out_valid_o),
   .out_two_o   (out_two_o),
   .out_last_o  (out_last_o),
   .spd_o       (spd_o),
   .spd_err_o   (spd_err_o),
   .stat_valid_o(stat_valid_o)
);

// File: tb/dual_rx_deformatter_bench.sv
`timescale 1ns/1ps
module dual_rx_deformatter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ctl = 2'b00;
   logic [7:0]  dlo = 8'h00;
   logic [7:0]  dhi = 8'h00;
   logic        hv = 1'b0;
   logic        out_valid, out_two, out_last, legacy, spd_err, stat_v;
   logic [15:0] out_data;
   logic [2:0]  spd;
   logic [7:0]  stat;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   byte unsigned got_q[$];
   byte unsigned exp_q[$];
   int n_last, last_idx, n_err, n_stat;
   logic [7:0] stat_seen;

   always #2 clk = ~clk;

   dual_rx_deformatter u_dual_rx_deformatter (
      .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .dlo_i(dlo), .dhi_i(dhi), .hv_i(hv),
      .out_valid_o(out_valid), .out_data_o(out_data), .out_two_o(out_two),
      .out_last_o(out_last), .spd_o(spd), .legacy_o(legacy), .spd_err_o(spd_err),
      .stat_valid_o(stat_v), .stat_o(stat)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            got_q.push_back(out_data[7:0]);
            if (out_two) got_q.push_back(out_data[15:8]);
            if (out_last) begin
               n_last++;
               last_idx = got_q.size() - 1;
            end
         end
         if (spd_err) n_err++;
         if (stat_v) begin
            n_stat++;
            stat_seen = stat;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] code_of(input int s, input bit leg);
      case (s)
         0: return leg ? 8'h00 : 8'h01;
         1: return leg ? 8'h04 : 8'h05;
         2: return leg ? 8'h08 : 8'h09;
         3: return 8'h0D;
         4: return 8'h0F;
         default: return 8'h0B;
      endcase
   endfunction

   function automatic int rep_of(input int s);
      return (s <= 3) ? (16 >> s) : 1;
   endfunction

   task automatic drv(input logic [1:0] c, input logic [7:0] lo, input logic [7:0] hi, input logic v);
      @(negedge clk);
      ctl = c; dlo = lo; dhi = hi; hv = v;
   endtask

   task automatic clear_obs();
      got_q.delete(); exp_q.delete();
      n_last = 0; last_idx = -1; n_err = 0; n_stat = 0;
   endtask

   task automatic send(input int s, input logic [7:0] code, input int n,
                       input bit with_stat, input logic [7:0] st, input bit announce);
      bit top;
      top = (s == 5);
      for (int i = 0; i < n; i++) exp_q.push_back(8'($urandom_range(0, 254)));
      drv(2'b00, 8'h00, 8'h00, 1'b0);
      if (announce) begin
         drv(2'b10, 8'hFF, 8'h00, 1'b0);
         if (with_stat) begin
            drv(2'b01, st, 8'h00, 1'b0);
            drv(2'b10, 8'hFF, 8'h00, 1'b0);
         end
      end
      drv(2'b10, code, 8'h00, 1'b0);
      if (top) begin
         for (int i = 0; i < n; i += 2) begin
            if (i + 1 < n) drv(2'b10, exp_q[i], exp_q[i+1], 1'b1);
            else           drv(2'b10, exp_q[i], 8'($urandom), 1'b0);
         end
      end else begin
         for (int i = 0; i < n; i++)
            for (int r = 0; r < rep_of(s); r++)
               drv(2'b10, exp_q[i], 8'($urandom), 1'($urandom));
      end
      drv(2'b00, 8'h00, 8'h00, 1'b0);
      drv(2'b00, 8'h00, 8'h00, 1'b0);
      drv(2'b00, 8'h00, 8'h00, 1'b0);
   endtask

   task automatic verify(input string req, input int s, input bit leg);
      bit same;
      check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
      same = (got_q.size() == exp_q.size());
      if (same) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) same = 0;
      check(same, {req, " byte content"}, same, 1);
      check(n_last == 1 && last_idx == exp_q.size() - 1, "R10 last marker", last_idx, exp_q.size() - 1);
      check(spd == 3'(s), "R4 speed", spd, s);
      check(legacy == leg, "R4 legacy", legacy, leg);
   endtask

   initial begin
      void'($urandom(32'd4242));
      clear_obs();
      repeat (3) @(negedge clk);
      check(out_valid == 0 && out_last == 0 && out_two == 0, "R1 reset data outputs", out_valid, 0);
      check(spd_err == 0 && stat_v == 0 && spd == 0, "R1 reset flags", spd, 0);
      rst_n = 1'b1;

      // R4 every defined speed code
      for (int s = 0; s < 6; s++)
         for (int l = 0; l < 2; l++) begin
            if (l == 1 && s > 2) continue;
            clear_obs();
            send(s, code_of(s, l[0]), 3, 0, 8'h00, 1);
            verify("R4 R8 R9 code sweep", s, l[0]);
         end

      // R6 R7 top speed even and odd lengths
      clear_obs(); send(5, 8'h0B, 8, 0, 8'h00, 1); verify("R6 even top", 5, 0);
      clear_obs(); send(5, 8'h0B, 7, 0, 8'h00, 1); verify("R7 odd top", 5, 0);
      clear_obs(); send(5, 8'h0B, 1, 0, 8'h00, 1); verify("R7 single byte top", 5, 0);

      // R3 status during announcement
      clear_obs(); send(4, 8'h0F, 4, 1, 8'h5A, 1);
      check(n_stat == 1, "R3 status pulses", n_stat, 1);
      check(stat_seen == 8'h5A, "R3 status value", stat_seen, 8'h5A);
      verify("R3 packet after status", 4, 0);

      // R5 undefined speed code
      clear_obs(); send(4, 8'h02, 5, 0, 8'h00, 1);
      check(n_err == 1, "R5 error pulse", n_err, 1);
      check(got_q.size() == 0, "R5 packet dropped", got_q.size(), 0);
      clear_obs(); send(5, 8'h0B, 4, 0, 8'h00, 1); verify("R5 recovery", 5, 0);

      // R2 no announcement
      clear_obs(); send(4, 8'h0F, 5, 0, 8'h00, 0);
      check(got_q.size() == 0, "R2 no announcement", got_q.size(), 0);

      // R8 R9 R11 random mix
      for (int k = 0; k < 30; k++) begin
         int s; bit l; int n;
         s = $urandom_range(0, 5);
         l = (s <= 2) ? 1'($urandom) : 1'b0;
         n = $urandom_range(1, (s <= 1) ? 10 : 24);
         clear_obs();
         send(s, code_of(s, l), n, 1'($urandom), 8'($urandom), 1);
         verify("R11 random packet", s, l);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule